// File: doc/BRIEF.md
# Bitwise EEPROM Program Sequencer

This block stands between a serial command decoder and a small nonvolatile bit array. It turns one-cycle command strobes into the long erase and program intervals that a charge pump needs. The array is a behavioural register of `NBITS` bits, and the pump is modelled only as a down-counter. A bulk erase clears every bit to 0. Individual bits can then be set to 1 with a begin/end pair that names the same address. Clearing a bit is possible only through erase.

Erase, begin and end are taken only while both the write-enable level and the chip-select level are high. While a pump interval runs, `busy` is high and every such command is turned away, and the attempt is remembered in a sticky flag. An end that names a different address from the pending begin is also turned away and flagged. A saturating wear counter tracks accepted erases and refuses further erases once the limit is reached. Single-bit reads for the serial receiver are served at any time while chip-select is high, including during a pump interval.

Top module: `nvm_bitprog_seq`

## Requirements
- R1: After reset, `busy`, `rd_valid`, `viol_busy`, `viol_seq` and `wear_limit` are 0, `erase_count` is 0, and every array bit reads 0.
- R2: An accepted erase clears all array bits to 0, ignores `cmd_addr`, and holds `busy` high for exactly `T_LONG` cycles, starting with the cycle after the strobe.
- R3: A begin at address A holds `busy` for `T_LONG` cycles and leaves A pending. A later end at A sets bit A to 1, leaves all other bits unchanged, and holds `busy` for exactly `T_SETTLE` cycles.
- R4: Erase, begin and end strobes are ignored unless `wr_en` and `chip_sel` are both high. An ignored strobe raises neither `busy` nor any flag, and it leaves the array unchanged.
- R5: An erase, begin or end that passes the gating while `busy` is high is rejected. It leaves the array and the pending address unchanged and sets `viol_busy`.
- R6: An end whose address differs from the pending begin address is rejected and sets `viol_seq`. It does not start a busy interval, and the begin stays pending, so that a later end at the correct address still sets the bit.
- R7: An end with no begin pending changes no bit and starts a `T_SETTLE` busy interval. This covers the end at address 0 that follows an erase.
- R8: A read strobe taken while `chip_sel` is high gives `rd_valid` high for one cycle on the next cycle, with `rd_bit` equal to the stored bit at `cmd_addr`. This works even while `busy` is high. When `chip_sel` is low, no `rd_valid` is produced.
- R9: Each accepted erase adds 1 to `erase_count`. When the count reaches `ERASE_LIMIT` (default 100), `wear_limit` goes high and later erases are refused: the array, the count and `busy` are left unchanged.
- R10: `viol_busy` and `viol_seq` stay high once set and are cleared only by reset.
- R11: An accepted erase cancels any pending begin, so that a later end at that address behaves as in R7.
- R12: When two or more of the erase, begin and end strobes are asserted in the same cycle, erase takes precedence over begin, and begin takes precedence over end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write-enable level; permits erase and programming |
| chip_sel | input | 1 | Chip-select level; gates all commands |
| cmd_erase | input | 1 | Bulk-erase strobe |
| cmd_wr_begin | input | 1 | Begin-program strobe |
| cmd_wr_end | input | 1 | End-program strobe |
| cmd_read | input | 1 | Single-bit read strobe |
| cmd_addr | input | $clog2(NBITS) | Bit address for begin, end and read |
| busy | output | 1 | Pump interval in progress |
| rd_valid | output | 1 | Read result valid |
| rd_bit | output | 1 | Read result |
| viol_busy | output | 1 | Sticky: command arrived while busy |
| viol_seq | output | 1 | Sticky: end address mismatched pending begin |
| erase_count | output | $clog2(ERASE_LIMIT+1) | Accepted erase count, saturating |
| wear_limit | output | 1 | Erase count has reached the limit |

## Verification
The hardest state to reach from the ports is the wear limit. Reaching it takes a hundred complete erase intervals, and a refused erase can only be seen through an array bit that it would otherwise have cleared. The bench shortens the pump intervals through parameters and runs an erase loop up to the limit. It then programs one bit, issues one more erase, and reads that bit back. A second hard case is the rejected mismatched end: the bench shows that the begin is still pending by completing the pair at the correct address afterwards.

// File: rtl/nvm_bitprog_pkg.sv
package nvm_bitprog_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_ERASE = 2'd1,
      OP_BEGIN = 2'd2,
      OP_END   = 2'd3
   } nvm_op_e;

   function automatic int unsigned cnt_width(input int unsigned maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction

endpackage

// File: rtl/nvm_pump_timer.sv
module nvm_pump_timer #(
   parameter int unsigned T_LONG   = 2_500_000,
   parameter int unsigned T_SETTLE = 50_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_long,
   input  logic load_short,
   output logic busy_o
);
   import nvm_bitprog_pkg::*;

   localparam int unsigned CW = cnt_width(T_LONG);

   if (T_LONG < 2)         begin : g_chk_long   $error("T_LONG must be at least 2"); end
   if (T_SETTLE < 1)       begin : g_chk_settle $error("T_SETTLE must be at least 1"); end
   if (T_SETTLE > T_LONG)  begin : g_chk_order  $error("T_SETTLE must not exceed T_LONG"); end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (load_long)        cnt_q <= CW'(T_LONG);
      else if (load_short)       cnt_q <= CW'(T_SETTLE);
      else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);

   // R5: a new interval is only ever started from idle
   a_r5_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (load_long || load_short) |-> !busy_o);

   // R2: the two interval lengths are never requested together
   a_r2_single_load: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_long && load_short));

   // R2: a long load is followed by a busy cycle
   a_r2_busy_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
      load_long |=> busy_o);

endmodule

// File: rtl/nvm_bit_array.sv
module nvm_bit_array #(
   parameter int unsigned NBITS = 128,
   localparam int unsigned AW   = $clog2(NBITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             set,
   input  logic [AW-1:0]    set_addr,
   output logic [NBITS-1:0] bits_o
);

   if (NBITS < 2 || NBITS > 4096) begin : g_chk_nbits
      $error("NBITS out of range");
   end
   if ((1 << AW) != NBITS) begin : g_chk_pow2
      $error("NBITS must be a power of two");
   end

   for (genvar i = 0; i < NBITS; i++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              bits_o[i] <= 1'b0;
         else if (clr)                            bits_o[i] <= 1'b0;
         else if (set && (set_addr == AW'(i)))    bits_o[i] <= 1'b1;
      end
   end

   // R3: without an erase no bit ever returns to 0
   a_r3_only_erase_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (($past(bits_o) & ~bits_o) == '0));

   // R2: erase and set are never requested together
   a_r2_clr_excl_set: assert property (@(posedge clk) disable iff (!rst_n)
      !(clr && set));

endmodule

// File: rtl/nvm_wear_counter.sv
module nvm_wear_counter #(
   parameter int unsigned LIMIT = 100,
   localparam int unsigned CW   = nvm_bitprog_pkg::cnt_width(LIMIT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   output logic [CW-1:0] count_o,
   output logic          at_limit_o
);

   if (LIMIT < 1) begin : g_chk_limit
      $error("LIMIT must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           count_o <= '0;
      else if (inc && !at_limit_o)          count_o <= count_o + 1'b1;
   end

   assign at_limit_o = (count_o == CW'(LIMIT));

   // R9: the count never passes the limit
   a_r9_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
      count_o <= CW'(LIMIT));

   // R9: at the limit the count holds
   a_r9_hold_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
      at_limit_o |=> $stable(count_o));

endmodule

// File: rtl/nvm_bitprog_seq.sv
module nvm_bitprog_seq #(
   parameter int unsigned NBITS       = 128,
   parameter int unsigned T_LONG      = 2_500_000,
   parameter int unsigned T_SETTLE    = 50_000,
   parameter int unsigned ERASE_LIMIT = 100,
   parameter bit          WEAR_EN     = 1'b1,
   localparam int unsigned AW         = $clog2(NBITS),
   localparam int unsigned ECW        = nvm_bitprog_pkg::cnt_width(ERASE_LIMIT)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic           chip_sel,
   input  logic           cmd_erase,
   input  logic           cmd_wr_begin,
   input  logic           cmd_wr_end,
   input  logic           cmd_read,
   input  logic [AW-1:0]  cmd_addr,
   output logic           busy,
   output logic           rd_valid,
   output logic           rd_bit,
   output logic           viol_busy,
   output logic           viol_seq,
   output logic [ECW-1:0] erase_count,
   output logic           wear_limit
);
   import nvm_bitprog_pkg::*;

   nvm_op_e          op;
   logic             wr_ok;
   logic             armed_q;
   logic [AW-1:0]    pend_q;
   logic             erase_go, begin_go, end_go, end_bad, set_go, hit_busy;
   logic [NBITS-1:0] bits_w;

   // R12: erase > begin > end
   always_comb begin
      if (cmd_erase)          op = OP_ERASE;
      else if (cmd_wr_begin)  op = OP_BEGIN;
      else if (cmd_wr_end)    op = OP_END;
      else                    op = OP_NONE;
   end

   assign wr_ok    = wr_en && chip_sel;
   assign hit_busy = wr_ok && busy && (op != OP_NONE);
   assign erase_go = wr_ok && !busy && (op == OP_ERASE) && !wear_limit;
   assign begin_go = wr_ok && !busy && (op == OP_BEGIN);
   assign end_bad  = wr_ok && !busy && (op == OP_END) && armed_q && (pend_q != cmd_addr);
   assign end_go   = wr_ok && !busy && (op == OP_END) && !end_bad;
   assign set_go   = end_go && armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         pend_q  <= '0;
      end else if (erase_go || set_go) begin
         armed_q <= 1'b0;
      end else if (begin_go) begin
         armed_q <= 1'b1;
         pend_q  <= cmd_addr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         viol_busy <= 1'b0;
         viol_seq  <= 1'b0;
      end else begin
         viol_busy <= viol_busy | hit_busy;
         viol_seq  <= viol_seq  | end_bad;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_bit   <= 1'b0;
      end else begin
         rd_valid <= cmd_read && chip_sel;
         if (cmd_read && chip_sel) rd_bit <= bits_w[cmd_addr];
      end
   end

   nvm_pump_timer #(.T_LONG(T_LONG), .T_SETTLE(T_SETTLE)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_long  (erase_go || begin_go),
      .load_short (end_go),
      .busy_o     (busy)
   );

   nvm_bit_array #(.NBITS(NBITS)) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (erase_go),
      .set      (set_go),
      .set_addr (cmd_addr),
      .bits_o   (bits_w)
   );

   if (WEAR_EN) begin : g_wear
      nvm_wear_counter #(.LIMIT(ERASE_LIMIT)) u_wear (
         .clk        (clk),
         .rst_n      (rst_n),
         .inc        (erase_go),
         .count_o    (erase_count),
         .at_limit_o (wear_limit)
      );
   end else begin : g_no_wear
      assign erase_count = '0;
      assign wear_limit  = 1'b0;
   end

   // R2: an accepted erase leaves the array all zero
   a_r2_erase_clears: assert property (@(posedge clk) disable iff (!rst_n)
      erase_go |=> (bits_w == '0));

   // R3: a completed pair lands a 1 at its address
   a_r3_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
      set_go |=> bits_w[$past(cmd_addr)]);

   // R4: blocked strobes never start an interval
   a_r4_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_ok && !busy) |=> !busy);

   // R5: the array is frozen throughout a busy interval
   a_r5_busy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(bits_w));

   // R6: a mismatched end starts no interval
   a_r6_bad_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
      end_bad |=> !busy);

   // R8: a selected read answers on the next cycle
   a_r8_read_answer: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_read && chip_sel) |=> rd_valid);

   // R10: violation flags are sticky
   a_r10_busy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      viol_busy |=> viol_busy);
   a_r10_seq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      viol_seq |=> viol_seq);

endmodule

// File: tb/nvm_bitprog_seq_tb.sv
module nvm_bitprog_seq_tb;

   localparam int NB = 128;
   localparam int TL = 20;
   localparam int TS = 5;
   localparam int LIM = 100;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b1, chip_sel = 1'b1;
   logic       cmd_erase = 1'b0, cmd_wr_begin = 1'b0, cmd_wr_end = 1'b0, cmd_read = 1'b0;
   logic [6:0] cmd_addr = '0;
   logic       busy, rd_valid, rd_bit, viol_busy, viol_seq, wear_limit;
   logic [6:0] erase_count;

   int n_chk = 0, n_fail = 0;
   logic  exp_q[$];
   string req_q[$];

   always #10 clk = ~clk;

   nvm_bitprog_seq #(.NBITS(NB), .T_LONG(TL), .T_SETTLE(TS), .ERASE_LIMIT(LIM)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .chip_sel(chip_sel),
      .cmd_erase(cmd_erase), .cmd_wr_begin(cmd_wr_begin), .cmd_wr_end(cmd_wr_end),
      .cmd_read(cmd_read), .cmd_addr(cmd_addr), .busy(busy), .rd_valid(rd_valid),
      .rd_bit(rd_bit), .viol_busy(viol_busy), .viol_seq(viol_seq),
      .erase_count(erase_count), .wear_limit(wear_limit));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: pops expected read results as the design returns them
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            chk("R8 unexpected rd_valid", 1, 0);
         end else begin
            chk(req_q.pop_front(), int'(rd_bit), int'(exp_q.pop_front()));
         end
      end
   end

   localparam int K_ERASE = 0, K_BEGIN = 1, K_END = 2, K_ALL = 3;

   task automatic issue(input int kind, input int a);
      @(negedge clk);
      cmd_addr = 7'(a);
      cmd_erase    = (kind == K_ERASE) || (kind == K_ALL);
      cmd_wr_begin = (kind == K_BEGIN) || (kind == K_ALL);
      cmd_wr_end   = (kind == K_END)   || (kind == K_ALL);
      @(negedge clk);
      cmd_erase = 1'b0; cmd_wr_begin = 1'b0; cmd_wr_end = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy) begin n++; @(negedge clk); end
   endtask

   // driver: pushes the expected bit into the scoreboard when selected
   task automatic rd(input int a, input logic exp, input string req);
      @(negedge clk);
      cmd_addr = 7'(a);
      cmd_read = 1'b1;
      if (chip_sel) begin exp_q.push_back(exp); req_q.push_back(req); end
      @(negedge clk);
      cmd_read = 1'b0;
   endtask

   task automatic set_bit(input int a);
      int n;
      issue(K_BEGIN, a); wait_idle(n);
      issue(K_END, a);   wait_idle(n);
   endtask

   int exp_cnt = 0;

   initial begin
      #(20 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk("R1 busy", busy, 0);
      chk("R1 viol_busy", viol_busy, 0);
      chk("R1 viol_seq", viol_seq, 0);
      chk("R1 erase_count", erase_count, 0);
      chk("R1 wear_limit", wear_limit, 0);
      rd(0, 0, "R1 bit0"); rd(127, 0, "R1 bit127");

      // R2 erase interval, R7 end without begin
      issue(K_ERASE, 55); wait_idle(n); exp_cnt++;
      chk("R2 erase busy cycles", n, TL);
      chk("R9 count after erase", erase_count, exp_cnt);
      issue(K_END, 0); wait_idle(n);
      chk("R7 settle cycles", n, TS);
      rd(0, 0, "R7 bit0 unchanged");

      // R3 program pair
      issue(K_BEGIN, 5); wait_idle(n);
      chk("R3 begin busy cycles", n, TL);
      issue(K_END, 5); wait_idle(n);
      chk("R3 end settle cycles", n, TS);
      set_bit(127); set_bit(0);
      rd(5, 1, "R3 bit5 set"); rd(4, 0, "R3 bit4 clear");
      rd(6, 0, "R3 bit6 clear"); rd(127, 1, "R3 bit127 set"); rd(0, 1, "R3 bit0 set");

      // R4 gating
      wr_en = 1'b0;
      issue(K_ERASE, 0);
      chk("R4 wr_en low no busy", busy, 0);
      wr_en = 1'b1; chip_sel = 1'b0;
      issue(K_ERASE, 0);
      chk("R4 cs low no busy", busy, 0);
      rd(5, 0, "R8 unselected read");
      chip_sel = 1'b1;
      chk("R4 no viol", viol_busy, 0);
      chk("R4 count unchanged", erase_count, exp_cnt);
      rd(5, 1, "R4 bit5 kept");

      // R5 command during busy
      issue(K_BEGIN, 9);
      issue(K_ERASE, 0);
      chk("R5 viol_busy set", viol_busy, 1);
      wait_idle(n);
      issue(K_END, 9); wait_idle(n);
      rd(9, 1, "R5 pair survives"); rd(5, 1, "R5 erase rejected");
      chk("R5 count unchanged", erase_count, exp_cnt);

      // R6 mismatched end
      issue(K_BEGIN, 20); wait_idle(n);
      issue(K_END, 21);
      chk("R6 no busy", busy, 0);
      chk("R6 viol_seq", viol_seq, 1);
      rd(21, 0, "R6 bit21 clear"); rd(20, 0, "R6 bit20 not yet");
      issue(K_END, 20); wait_idle(n);
      rd(20, 1, "R6 bit20 after good end");

      // R12 priority: erase wins over begin/end
      issue(K_ALL, 40); wait_idle(n); exp_cnt++;
      chk("R12 erase chosen busy", n, TL);
      rd(5, 0, "R12 array cleared"); rd(40, 0, "R12 no set");

      // R11 erase cancels pending
      issue(K_BEGIN, 30); wait_idle(n);
      issue(K_ERASE, 0); wait_idle(n); exp_cnt++;
      issue(K_END, 30); wait_idle(n);
      chk("R11 end acts as no-op settle", n, TS);
      rd(30, 0, "R11 bit30 clear");

      // R8 read during busy
      set_bit(50);
      issue(K_ERASE, 0); exp_cnt++;
      rd(50, 0, "R8 read while busy");
      chk("R8 still busy", busy, 1);
      wait_idle(n);

      // R10 flags held
      chk("R10 viol_busy held", viol_busy, 1);
      chk("R10 viol_seq held", viol_seq, 1);

      // R9 wear limit
      while (exp_cnt < LIM - 1) begin
         issue(K_ERASE, 0); wait_idle(n); exp_cnt++;
      end
      chk("R9 count 99", erase_count, LIM - 1);
      chk("R9 no flag at 99", wear_limit, 0);
      issue(K_ERASE, 0); wait_idle(n); exp_cnt++;
      chk("R9 count at limit", erase_count, LIM);
      chk("R9 wear flag", wear_limit, 1);
      set_bit(3);
      issue(K_ERASE, 0);
      chk("R9 refused erase no busy", busy, 0);
      chk("R9 count held", erase_count, LIM);
      rd(3, 1, "R9 bit3 survives refused erase");

      repeat (3) @(negedge clk);
      chk("R8 scoreboard drained", exp_q.size(), 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule